// File: doc/BRIEF.md
# Cache Block Refill Sequencer

After a cache miss, this block fetches one four-word block from main memory and hands the words to the cache fill path. It takes a block address through a ready/valid request port. It then spends one cycle sending the address, starts one or more memory accesses, and moves the data back. Each delivery cycle shows, on a block-wide data bus, which word slots are valid, and it flags the final beat of the refill.

A build-time parameter selects one of three memory organizations:

- **Narrow:** the memory is one word wide, so each word needs its own access.
- **Wide:** the memory is as wide as the block, so one access returns every word at once.
- **Interleaved:** four independent banks start their accesses together, and the words then leave over a one-word path one per cycle.

The memory is modelled as behavioural banks with a fixed access time. Each bank returns a word computed from its word address, so a fetched value proves which address was read.

Timing convention: cycle 1 is the first clock cycle after the rising edge that accepts the request. Cycle n is the cycle after the n-th such edge counted from acceptance.

Top module: `refill_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `fill_mask` is all zero and `fill_last` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from cycle 1 until the refill ends. A `req_valid` pulse while busy has no effect: no extra words are delivered, and the running refill's data and timing are unchanged.
- R3: Narrow organization (ORG=0), access time L=15: word k appears in cycle 1+(k+1)(L+1), which is cycles 17, 33, 49 and 65. A refill therefore lasts 65 cycles.
- R4: Wide organization (ORG=1): all four words appear together in cycle L+2 = 17, with `fill_mask` = 4'b1111.
- R5: Interleaved organization (ORG=2): word k appears in cycle L+2+k, which is cycles 17, 18, 19 and 20. A refill therefore lasts 20 cycles.
- R6: Words are delivered in ascending offset order.
  - Word offset k appears in slot k, which is `fill_data[32k+31:32k]`, and is marked by `fill_mask[k]`.
  - In the narrow and interleaved organizations at most one mask bit is set per cycle.
  - The data of word k for block address A equals W*65539 XOR 32'h5A5A5A5A, truncated to 32 bits, where W = A*4+k.
- R7: `fill_last` is 1 exactly in the cycle that delivers offset 3, the last word. `req_ready` returns to 1 in the following cycle, when a new request may be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request |
| req_addr | input | BLK_AW (16) | Block address of the missing block |
| req_ready | output | 1 | Sequencer idle; a request is taken this cycle |
| fill_mask | output | WORDS (4) | Word slots valid this cycle |
| fill_data | output | 32*WORDS (128) | Block-wide data, slot k in bits 32k+31:32k |
| fill_last | output | 1 | Last delivery beat of the refill |

## Verification
The same stimulus is applied to all three organizations: a single refill with nothing else going on, a refill disturbed by a stray request while busy, and consecutive refills to an all-ones block address and to low addresses. Comparing the cycle of every word separates the three latency models (65, 17 and 20 cycles). Comparing slot and data separates correct offset ordering from swapped or misaddressed words. The stray request and the follow-on refills show whether requests are gated by idleness, and whether the sequencer returns to idle one cycle after the last word.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WAIT, ST_XFER} seq_st_e;

  // Deterministic memory content: one word per word address.
  function automatic logic [WORD_W-1:0] mem_word(input logic [31:0] waddr);
    return (waddr * 32'h0001_0003) ^ 32'h5A5A_5A5A;
  endfunction

  // Cycles from the accepting edge to the last delivered word.
  function automatic int refill_cycles(input int org, input int words, input int lat);
    case (org)
      0:       return 1 + words * (lat + 1);
      1:       return 2 + lat;
      default: return 1 + lat + words;
    endcase
  endfunction
endpackage

// File: rtl/refill_mem_bank.sv
module refill_mem_bank import refill_pkg::*; #(
  parameter int WAW     = 18,
  parameter int ACC_LAT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAW-1:0]    waddr,
  output logic              done,
  output logic [WORD_W-1:0] rdata
);
  localparam int CW = $clog2(ACC_LAT + 1);

  logic [CW-1:0]  rem;
  logic [WAW-1:0] addr_q;

  // done marks the final access cycle; the word is registered on that edge
  assign done = (rem == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem    <= '0;
      addr_q <= '0;
      rdata  <= '0;
    end else begin
      if (start) begin
        rem    <= CW'(ACC_LAT - 1);
        addr_q <= waddr;
      end else if (rem != '0) begin
        rem <= rem - 1'b1;
      end
      if (done) rdata <= mem_word(32'(addr_q));
    end
  end
endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl import refill_pkg::*; #(
  parameter int ORG    = 0,
  parameter int WORDS  = 4,
  parameter int BLK_AW = 16,
  parameter int NB     = 1,
  parameter int OFF_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [BLK_AW-1:0]              req_addr,
  input  logic                           access_done,
  output logic                           req_ready,
  output logic                           accept,
  output logic [NB-1:0]                  bank_start,
  output logic [NB-1:0][BLK_AW+OFF_W-1:0] bank_waddr,
  output logic                           xfer_beat,
  output logic                           last_beat,
  output logic [OFF_W-1:0]               widx
);
  seq_st_e           st;
  logic              first_q;
  logic [BLK_AW-1:0] blk_q;

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign xfer_beat  = (st == ST_XFER);
  assign last_beat  = xfer_beat && ((ORG == 1) || (widx == OFF_W'(WORDS - 1)));
  assign bank_start = {NB{(st == ST_WAIT) && first_q}};

  for (genvar b = 0; b < NB; b++) begin : g_addr
    if (ORG == 0) begin : g_narrow
      assign bank_waddr[b] = {blk_q, widx};
    end else begin : g_multi
      assign bank_waddr[b] = {blk_q, OFF_W'(b)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      first_q <= 1'b0;
      blk_q   <= '0;
      widx    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st    <= ST_ADDR;
          blk_q <= req_addr;
          widx  <= '0;
        end
        ST_ADDR: begin
          st      <= ST_WAIT;
          first_q <= 1'b1;
        end
        ST_WAIT: begin
          first_q <= 1'b0;
          if (access_done) st <= ST_XFER;
        end
        default: begin
          if (last_beat) begin
            st <= ST_IDLE;
          end else begin
            widx <= widx + 1'b1;
            if (ORG == 0) begin
              st      <= ST_WAIT;
              first_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/refill_deliver.sv
module refill_deliver import refill_pkg::*; #(
  parameter int ORG   = 0,
  parameter int WORDS = 4,
  parameter int NB    = 1,
  parameter int OFF_W = 2
) (
  input  logic                         xfer_beat,
  input  logic                         last_beat,
  input  logic [OFF_W-1:0]             widx,
  input  logic [NB-1:0][WORD_W-1:0]    bank_rdata,
  output logic [WORDS-1:0]             fill_mask,
  output logic [WORDS*WORD_W-1:0]      fill_data,
  output logic                         fill_last
);
  always_comb begin
    fill_mask = '0;
    if (xfer_beat) begin
      if (ORG == 1) fill_mask = '1;
      else          fill_mask[widx] = 1'b1;
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_slot
    localparam int SRC = (NB == 1) ? 0 : k;
    assign fill_data[k*WORD_W +: WORD_W] = bank_rdata[SRC];
  end

  assign fill_last = last_beat;
endmodule

// File: rtl/refill_seq.sv
module refill_seq import refill_pkg::*; #(
  parameter int ORG     = 0,
  parameter int WORDS   = 4,
  parameter int BLK_AW  = 16,
  parameter int ACC_LAT = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [BLK_AW-1:0]       req_addr,
  output logic                    req_ready,
  output logic [WORDS-1:0]        fill_mask,
  output logic [WORDS*WORD_W-1:0] fill_data,
  output logic                    fill_last
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int WAW   = BLK_AW + OFF_W;
  localparam int NB    = (ORG == 0) ? 1 : WORDS;

  logic                         accept;
  logic                         access_done;
  logic                         xfer_beat;
  logic                         last_beat;
  logic [OFF_W-1:0]             widx;
  logic [NB-1:0]                bank_start;
  logic [NB-1:0]                bank_done;
  logic [NB-1:0][WAW-1:0]       bank_waddr;
  logic [NB-1:0][WORD_W-1:0]    bank_rdata;

  // all banks run in lockstep; bank 0 speaks for the group
  assign access_done = bank_done[0];

  refill_ctrl #(
    .ORG(ORG), .WORDS(WORDS), .BLK_AW(BLK_AW), .NB(NB), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .access_done(access_done), .req_ready(req_ready), .accept(accept),
    .bank_start(bank_start), .bank_waddr(bank_waddr), .xfer_beat(xfer_beat),
    .last_beat(last_beat), .widx(widx)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    refill_mem_bank #(.WAW(WAW), .ACC_LAT(ACC_LAT)) u_bank (
      .clk(clk), .rst_n(rst_n), .start(bank_start[b]), .waddr(bank_waddr[b]),
      .done(bank_done[b]), .rdata(bank_rdata[b])
    );
  end

  refill_deliver #(.ORG(ORG), .WORDS(WORDS), .NB(NB), .OFF_W(OFF_W)) u_out (
    .xfer_beat(xfer_beat), .last_beat(last_beat), .widx(widx),
    .bank_rdata(bank_rdata), .fill_mask(fill_mask), .fill_data(fill_data),
    .fill_last(fill_last)
  );
endmodule

// File: rtl/refill_seq_chk.sv
module refill_seq_chk #(
  parameter int ORG     = 0,
  parameter int WORDS   = 4,
  parameter int ACC_LAT = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             accept,
  input logic [WORDS-1:0] fill_mask,
  input logic             fill_last
);
  localparam int TOTAL = refill_pkg::refill_cycles(ORG, WORDS, ACC_LAT);

  int unsigned since;
  always_ff @(posedge clk) begin
    if (!rst_n)            since <= 0;
    else if (accept)       since <= 1;
    else if (fill_last)    since <= 0;
    else if (since != 0)   since <= since + 1;
  end

  // R1
  busy_while_delivering_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_mask != '0) |-> !req_ready);

  // R2
  accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R3 R4 R5
  refill_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |-> (since == TOTAL));

  // R7
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> req_ready);

  // R7
  last_is_top_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |-> fill_mask[WORDS-1]);

  if (ORG == 1) begin : g_wide
    // R4
    whole_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_mask == '0) || (fill_mask == '1));
  end else begin : g_single
    // R6
    one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fill_mask));
  end

  if (ORG == 2) begin : g_inter
    // R6
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((fill_mask != '0) && !fill_last) |=> (fill_mask == ($past(fill_mask) << 1)));
  end
endmodule

bind refill_seq refill_seq_chk #(.ORG(ORG), .WORDS(WORDS), .ACC_LAT(ACC_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .accept(accept),
  .fill_mask(fill_mask), .fill_last(fill_last)
);

// File: tb/tb_refill_seq.sv
`timescale 1ns/1ps
module tb_refill_seq;
  localparam int LAT = 15;

  typedef struct {
    int          org;
    int          t;
    int          slot;
    logic [31:0] data;
    bit          last;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid [3];
  logic [15:0] req_addr  [3];
  logic        req_ready [3];
  logic [3:0]  fill_mask [3];
  logic [127:0] fill_data [3];
  logic        fill_last [3];
  int          cnt [3];
  item_t       expq [$];
  int          ntot = 0;
  int          nfail = 0;
  bit          ended = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < 3; g++) begin : org_g
    refill_seq #(.ORG(g), .WORDS(4), .BLK_AW(16), .ACC_LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid[g]), .req_addr(req_addr[g]),
      .req_ready(req_ready[g]), .fill_mask(fill_mask[g]), .fill_data(fill_data[g]),
      .fill_last(fill_last[g])
    );
  end

  function automatic logic [31:0] exp_word(input logic [15:0] a, input int k);
    logic [31:0] w;
    w = {14'd0, a, 2'(k)};
    return ((w << 16) + (w << 1) + w) ^ 32'h5A5A_5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // cycle counter since the accepting edge, restarted by each acceptance
  always @(posedge clk) begin
    for (int o = 0; o < 3; o++)
      if (req_valid[o] && req_ready[o]) cnt[o] <= 1;
      else cnt[o] <= cnt[o] + 1;
  end

  // monitor: compare every delivered word with the scoreboard head
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < 3; o++) begin
        for (int k = 0; k < 4; k++) begin
          if (fill_mask[o][k]) begin
            ntot++;
            if (expq.size() == 0) begin
              nfail++;
              $display("FAIL R2 unexpected word: org %0d t %0d slot %0d, expected none",
                       o, cnt[o], k);
            end else begin
              item_t it;
              logic [31:0] d;
              it = expq.pop_front();
              d  = fill_data[o][k*32 +: 32];
              if (it.org != o || it.t != cnt[o] || it.slot != k ||
                  it.data != d || it.last != fill_last[o]) begin
                nfail++;
                $display("FAIL %s word: actual org %0d t %0d slot %0d data %h last %0d, expected org %0d t %0d slot %0d data %h last %0d",
                         it.req, o, cnt[o], k, d, fill_last[o],
                         it.org, it.t, it.slot, it.data, it.last);
              end
            end
          end
        end
      end
    end
  end

  task automatic refill(input int o, input logic [15:0] a, input bit poke);
    int n;
    n = (o == 0) ? 1 + 4 * (LAT + 1) : (o == 1) ? LAT + 2 : LAT + 5;
    @(negedge clk);
    chk(req_ready[o] == 1'b1, "R7", "ready before request", int'(req_ready[o]), 1);
    req_valid[o] = 1'b1;
    req_addr[o]  = a;
    for (int k = 0; k < 4; k++) begin
      item_t it;
      it.org  = o;
      it.slot = k;
      it.data = exp_word(a, k);
      if (o == 0) begin
        it.t = (LAT + 1) * (k + 1) + 1; it.last = (k == 3); it.req = "R3";
      end else if (o == 1) begin
        it.t = LAT + 2; it.last = 1'b1; it.req = "R4";
      end else begin
        it.t = LAT + 2 + k; it.last = (k == 3); it.req = "R5";
      end
      expq.push_back(it);
    end
    @(negedge clk);
    req_valid[o] = 1'b0;
    chk(req_ready[o] == 1'b0, "R2", "ready in cycle 1", int'(req_ready[o]), 0);
    for (int t = 2; t <= n; t++) begin
      @(negedge clk);
      if (poke && t == 5) begin
        chk(req_ready[o] == 1'b0, "R2", "ready while busy", int'(req_ready[o]), 0);
        req_valid[o] = 1'b1;
        req_addr[o]  = ~a;
      end else begin
        req_valid[o] = 1'b0;
      end
    end
    chk(req_ready[o] == 1'b0, "R7", "ready on last-word cycle", int'(req_ready[o]), 0);
    chk(fill_last[o] == 1'b1, "R7", "last flag on final cycle", int'(fill_last[o]), 1);
    @(negedge clk);
    chk(req_ready[o] == 1'b1, "R7", "ready after last word", int'(req_ready[o]), 1);
    chk(fill_mask[o] == 4'b0, "R2", "no delivery after refill", int'(fill_mask[o]), 0);
  endtask

  initial begin
    #(20000 * 5);
    if (!ended) begin
      ended = 1'b1;
      ntot++;
      nfail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    for (int o = 0; o < 3; o++) begin
      req_valid[o] = 1'b0;
      req_addr[o]  = '0;
      cnt[o]       = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 3; o++) begin
      chk(req_ready[o] == 1'b1, "R1", "ready after reset", int'(req_ready[o]), 1);
      chk(fill_mask[o] == 4'b0, "R1", "mask after reset", int'(fill_mask[o]), 0);
      chk(fill_last[o] == 1'b0, "R1", "last after reset", int'(fill_last[o]), 0);
    end
    // R3 R6: narrow, plain then disturbed, then all-ones address
    refill(0, 16'h0123, 1'b0);
    refill(0, 16'h0456, 1'b1);
    refill(0, 16'hFFFF, 1'b0);
    // R4
    refill(1, 16'hBEEF, 1'b0);
    refill(1, 16'h0001, 1'b1);
    refill(1, 16'hFFFF, 1'b0);
    // R5 R6
    refill(2, 16'h0040, 1'b0);
    refill(2, 16'h7A5C, 1'b1);
    refill(2, 16'hFFFF, 1'b0);
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R6", "undelivered words left", expq.size(), 0);
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end
endmodule